// File: doc/BRIEF.md
# Multi-State Memory Chip Power Manager

This block manages the power state of every chip in a bank of separately controlled memory chips. Each chip sits in one of four states, from the most power-hungry to the least: Active, Standby, Nap and PowerDown. The block watches the request stream. A chip that has been left alone steps down one level at a time, and each level has its own programmable idle threshold. A request to a chip that is not Active starts a wake-up. The wake-up latency depends on the state the chip is leaving. The request is held off until that latency has passed.

A mode input switches every chip to a simpler two-state policy. Under it a chip is Active while it has work and drops straight to one shared base state as soon as it has none. Addresses are not interleaved: each chip owns one contiguous region of 2^CHIP_AW words, so the upper address bits pick the chip. A request touches only the chip that it addresses.

Top module: `mem_power_mgr`

## Requirements
- R1: State codes are 00 Active, 01 Standby, 10 Nap and 11 PowerDown. Chip c reports its state on `chip_state[2c+1:2c]`. While reset is asserted, and on the first cycles after release, every chip reads 00.
- R2: With `quad_mode`=1, an idle chip moves one level lower at the end of its (T+1)-th consecutive idle cycle in a state. T is `T_AS` in Active, `T_SN` in Standby and `T_NP` in Nap. PowerDown is kept. A cycle is idle when the chip has no presented request, no outstanding access, no completion and no wake-up in progress.
- R3: With `quad_mode`=0, an Active chip that goes idle moves to the state coded on `base_sel` at the end of its first idle cycle. If `base_sel`=00 it stays Active. A chip in any other state keeps that state until it is requested.
- R4: A request to an Active chip that is not waking sees `req_ready`=1 in the same cycle. The access is granted at that clock edge.
- R5: A request presented in cycle 0 to a chip in Standby, Nap or PowerDown keeps `req_ready` low through cycle L. `req_ready` goes high in cycle L+1, and the chip reads Active from then on. L is `L_SB`, `L_NAP` or `L_PD` for the state the chip was in.
- R6: The chip index is `req_addr[ADDR_W-1:CHIP_AW]`. Offsets 0 and 2^CHIP_AW-1 inside a region both select that region's chip.
- R7: A request changes the state of the addressed chip only. Every other chip keeps following its own idle schedule.
- R8: A chip with an outstanding granted access (grant without a matching `done_valid`/`done_chip`) never steps down. Its idle count restarts on each grant and on each completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| quad_mode | input | 1 | 1: four-state cascade, 0: two-state policy with base state |
| base_sel | input | 2 | Base state code used by the two-state policy |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Request address (upper CHIP_W bits select the chip) |
| req_ready | output | 1 | Addressed chip is Active and may take the access |
| done_valid | input | 1 | A granted access has completed |
| done_chip | input | CHIP_W | Chip whose access completed |
| chip_state | output | 2*NUM_CHIPS | Packed 2-bit state codes, chip 0 in the low bits |

## Verification
`req_ready` is combinational from the addressed chip's registered state. It is due in the same cycle for an Active chip and in cycle L+1 after presentation for a sleeping one. The bench counts falling edges from the moment it raises `req_valid` until ready is seen, and compares that count with 0 or L+1. A step down lands on the clock edge that ends the (T+1)-th idle cycle. The first idle cycle follows the edge that takes the completion. For that reason the bench counts idle edges from a fixed point after each completion. It then samples `chip_state` at the falling edge just after the threshold, and also one edge before it.

// File: rtl/mpm_pkg.sv
`timescale 1ns/1ps
package mpm_pkg;
  typedef enum logic [1:0] {
    PS_ACT  = 2'b00,
    PS_STBY = 2'b01,
    PS_NAP  = 2'b10,
    PS_PDN  = 2'b11
  } pwr_st_e;
endpackage

// File: rtl/mpm_addr_dec.sv
`timescale 1ns/1ps
module mpm_addr_dec #(
  parameter int NUM_CHIPS = 8,
  parameter int CHIP_W    = 3
) (
  input  logic                 valid,
  input  logic [CHIP_W-1:0]    chip_bits,
  output logic [NUM_CHIPS-1:0] sel
);
  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_sel
    assign sel[i] = valid && (chip_bits == CHIP_W'(i));
  end

  // R6: a request selects at most one chip
  always_comb begin
    a_sel_onehot_r6: assert ($onehot0(sel));
  end
endmodule

// File: rtl/mpm_chip_ctl.sv
`timescale 1ns/1ps
module mpm_chip_ctl
  import mpm_pkg::*;
#(
  parameter int T_AS  = 0,
  parameter int T_SN  = 94,
  parameter int T_NP  = 46875,
  parameter int L_SB  = 1,
  parameter int L_NAP = 8,
  parameter int L_PD  = 750,
  parameter int OUT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_mode,
  input  logic [1:0] base_sel,
  input  logic       hit,
  input  logic       done,
  output logic       rdy,
  output logic [1:0] st_o
);
  localparam int TMAX   = (T_AS > T_SN) ? ((T_AS > T_NP) ? T_AS : T_NP)
                                        : ((T_SN > T_NP) ? T_SN : T_NP);
  localparam int LMAX   = (L_SB > L_NAP) ? ((L_SB > L_PD) ? L_SB : L_PD)
                                         : ((L_NAP > L_PD) ? L_NAP : L_PD);
  localparam int IDLE_W = $clog2(TMAX + 2);
  localparam int WAKE_W = $clog2(LMAX + 1);
  localparam logic [IDLE_W-1:0] IC_ONE = IDLE_W'(1);
  localparam logic [IDLE_W-1:0] IC_MAX = '1;
  localparam logic [WAKE_W-1:0] WC_ONE = WAKE_W'(1);
  localparam logic [OUT_W-1:0]  OC_ONE = OUT_W'(1);

  pwr_st_e            st, st_n;
  logic               waking, wk_n;
  logic [WAKE_W-1:0]  wcnt, wc_n;
  logic [IDLE_W-1:0]  icnt, ic_n;
  logic [OUT_W-1:0]   outst, oc_n;
  logic [IDLE_W-1:0]  thr;
  logic [WAKE_W-1:0]  lat;
  logic               idle, grant, done_ok;

  always_comb begin
    unique case (st)
      PS_ACT:  thr = IDLE_W'(T_AS);
      PS_STBY: thr = IDLE_W'(T_SN);
      default: thr = IDLE_W'(T_NP);
    endcase
    unique case (st)
      PS_STBY: lat = WAKE_W'(L_SB);
      PS_NAP:  lat = WAKE_W'(L_NAP);
      default: lat = WAKE_W'(L_PD);
    endcase
  end

  assign rdy     = (st == PS_ACT) && !waking;
  assign grant   = hit && rdy;
  assign done_ok = done && (outst != '0);
  assign idle    = (outst == '0) && !hit && !done && !waking;
  assign st_o    = st;

  // next-state process
  always_comb begin
    st_n = st;
    wk_n = waking;
    wc_n = wcnt;
    ic_n = icnt;
    oc_n = outst;
    if (grant && !done_ok)      oc_n = outst + OC_ONE;
    else if (!grant && done_ok) oc_n = outst - OC_ONE;
    if (waking) begin
      ic_n = '0;
      if (wcnt == WC_ONE) begin
        st_n = PS_ACT;
        wk_n = 1'b0;
        wc_n = '0;
      end else begin
        wc_n = wcnt - WC_ONE;
      end
    end else if (hit && st != PS_ACT) begin
      wk_n = 1'b1;
      wc_n = lat;
      ic_n = '0;
    end else if (!idle) begin
      ic_n = '0;
    end else if (quad_mode) begin
      if (st != PS_PDN && icnt >= thr) begin
        st_n = pwr_st_e'(st + 2'd1);
        ic_n = '0;
      end else if (icnt != IC_MAX) begin
        ic_n = icnt + IC_ONE;
      end
    end else if (st == PS_ACT && base_sel != 2'b00) begin
      st_n = pwr_st_e'(base_sel);
      ic_n = '0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PS_ACT;
      waking <= 1'b0;
      wcnt   <= '0;
      icnt   <= '0;
      outst  <= '0;
    end else begin
      st     <= st_n;
      waking <= wk_n;
      wcnt   <= wc_n;
      icnt   <= ic_n;
      outst  <= oc_n;
    end
  end

  // R2: in the cascade a state change downward is exactly one level
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(quad_mode) && st != $past(st) && st != PS_ACT)
      |-> (st == pwr_st_e'($past(st) + 2'd1)));

  // R3: in the two-state policy Active falls straight to the base code
  p_dual_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(quad_mode) && $past(st) == PS_ACT && st != PS_ACT)
      |-> (st == pwr_st_e'($past(base_sel))));

  // R5: Active is re-entered only when the wake countdown expires
  p_wake_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ACT && $past(st) != PS_ACT)
      |-> ($past(waking) && $past(wcnt) == WC_ONE));

  // R7: a wake-up starts only from a request to this chip
  p_wake_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waking) |-> $past(hit));

  // R8: no step down while an access is outstanding
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(outst) != '0) |-> !(st != $past(st) && st != PS_ACT));

  // R8: the outstanding counter never wraps
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !done_ok && outst == '1) |=> 1'b0);
endmodule

// File: rtl/mem_power_mgr.sv
`timescale 1ns/1ps
module mem_power_mgr #(
  parameter int NUM_CHIPS = 8,
  parameter int CHIP_AW   = 20,
  parameter int T_AS      = 0,
  parameter int T_SN      = 94,
  parameter int T_NP      = 46875,
  parameter int L_SB      = 1,
  parameter int L_NAP     = 8,
  parameter int L_PD      = 750,
  parameter int OUT_W     = 3,
  parameter int CHIP_W    = $clog2(NUM_CHIPS),
  parameter int ADDR_W    = CHIP_AW + CHIP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   quad_mode,
  input  logic [1:0]             base_sel,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   req_ready,
  input  logic                   done_valid,
  input  logic [CHIP_W-1:0]      done_chip,
  output logic [2*NUM_CHIPS-1:0] chip_state
);
  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [NUM_CHIPS-1:0] sel, done_vec, rdy_vec;
  logic [CHIP_W-1:0]    chip_bits;
  logic                 unused_addr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign chip_bits        = req_addr[ADDR_W-1 -: CHIP_W];
  assign unused_addr_bits = ^req_addr[CHIP_AW-1:0];

  mpm_addr_dec #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)) u_dec (
    .valid     (req_valid),
    .chip_bits (chip_bits),
    .sel       (sel)
  );

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
    assign done_vec[i] = done_valid && (done_chip == CHIP_W'(i));
    mpm_chip_ctl #(
      .T_AS(T_AS), .T_SN(T_SN), .T_NP(T_NP),
      .L_SB(L_SB), .L_NAP(L_NAP), .L_PD(L_PD), .OUT_W(OUT_W)
    ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .quad_mode (quad_mode),
      .base_sel  (base_sel),
      .hit       (sel[i]),
      .done      (done_vec[i]),
      .rdy       (rdy_vec[i]),
      .st_o      (chip_state[2*i +: 2])
    );
  end

  always_comb begin
    req_ready = 1'b0;
    for (int i = 0; i < NUM_CHIPS; i++) begin
      if (chip_bits == CHIP_W'(i)) req_ready = rdy_vec[i];
    end
  end
endmodule

// File: tb/mem_power_mgr_bench.sv
`timescale 1ns/1ps
module mem_power_mgr_bench;
  localparam int NCH  = 8;
  localparam int CAW  = 6;
  localparam int CW   = 3;
  localparam int AW   = CAW + CW;

  typedef struct packed {
    logic       quad;
    logic [1:0] base;
    logic [2:0] chip;
    logic [7:0] idle;
    logic [1:0] st;
    logic [7:0] lat;
  } vec_t;

  // thresholds 3/5/10 -> Active for idle<=3, Standby 4..9, Nap 10..20, PowerDown >=21
  // wake latencies 2/4/9 -> ready after 3/5/10 cycles
  localparam vec_t VECS [14] = '{
    '{1'b1, 2'd0, 3'd1, 8'd2,  2'd0, 8'd0},
    '{1'b1, 2'd0, 3'd1, 8'd4,  2'd1, 8'd3},
    '{1'b1, 2'd0, 3'd1, 8'd3,  2'd0, 8'd0},
    '{1'b1, 2'd0, 3'd3, 8'd9,  2'd1, 8'd3},
    '{1'b1, 2'd0, 3'd3, 8'd10, 2'd2, 8'd5},
    '{1'b1, 2'd0, 3'd3, 8'd20, 2'd2, 8'd5},
    '{1'b1, 2'd0, 3'd3, 8'd21, 2'd3, 8'd10},
    '{1'b1, 2'd0, 3'd4, 8'd40, 2'd3, 8'd10},
    '{1'b0, 2'd2, 3'd2, 8'd1,  2'd2, 8'd5},
    '{1'b0, 2'd3, 3'd2, 8'd4,  2'd3, 8'd10},
    '{1'b0, 2'd1, 3'd2, 8'd1,  2'd1, 8'd3},
    '{1'b0, 2'd0, 3'd2, 8'd6,  2'd0, 8'd0},
    '{1'b0, 2'd2, 3'd4, 8'd0,  2'd0, 8'd0},
    '{1'b1, 2'd0, 3'd1, 8'd12, 2'd2, 8'd5}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              quad_mode = 1'b1;
  logic [1:0]        base_sel = 2'd0;
  logic              req_valid = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic              req_ready;
  logic              done_valid = 1'b0;
  logic [CW-1:0]     done_chip = '0;
  logic [2*NCH-1:0]  chip_state;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mem_power_mgr #(
    .NUM_CHIPS(NCH), .CHIP_AW(CAW), .T_AS(3), .T_SN(5), .T_NP(10),
    .L_SB(2), .L_NAP(4), .L_PD(9), .OUT_W(2)
  ) u_mem_power_mgr (
    .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .base_sel(base_sel),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .done_valid(done_valid), .done_chip(done_chip), .chip_state(chip_state)
  );

  function automatic int st_of(input int c);
    return int'(chip_state[2*c +: 2]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // present a request, count cycles until ready, then complete it
  task automatic access(input int c, input int off, output int lat);
    req_addr  = AW'((c << CAW) | off);
    req_valid = 1'b1;
    lat = 0;
    #1;
    while (!req_ready && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    req_valid  = 1'b0;
    done_valid = 1'b1;
    done_chip  = CW'(c);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_up();
  end

  initial begin
    int lat;
    // R1: state while reset is held
    repeat (2) @(negedge clk);
    chk(chip_state == '0, "R1 states in reset", int'(chip_state), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(chip_state == '0, "R1 states after release", int'(chip_state), 0);

    // vector table: R2, R3, R4, R5
    for (int i = 0; i < 14; i++) begin
      quad_mode = VECS[i].quad;
      base_sel  = VECS[i].base;
      access(int'(VECS[i].chip), 1, lat);
      repeat (int'(VECS[i].idle)) @(negedge clk);
      chk(st_of(int'(VECS[i].chip)) == int'(VECS[i].st),
          VECS[i].quad ? "R2 state after idle" : "R3 state after idle",
          st_of(int'(VECS[i].chip)), int'(VECS[i].st));
      access(int'(VECS[i].chip), (i * 7) % 64, lat);
      chk(lat == int'(VECS[i].lat),
          (VECS[i].lat == 0) ? "R4 ready at once" : "R5 wake latency",
          lat, int'(VECS[i].lat));
    end

    // R7: chips never addressed kept their own schedule (PowerDown)
    chk(st_of(0) == 3, "R7 chip0 untouched", st_of(0), 3);
    chk(st_of(6) == 3, "R7 chip6 untouched", st_of(6), 3);

    // R6: region edges decode to the right chip
    quad_mode = 1'b1;
    access(6, 63, lat);
    chk(lat == 10, "R6 top offset selects chip6", lat, 10);
    chk(st_of(6) == 0, "R6 chip6 active", st_of(6), 0);
    chk(st_of(7) == 3, "R7 chip7 still down", st_of(7), 3);
    chk(st_of(5) == 3, "R7 chip5 still down", st_of(5), 3);
    access(5, 0, lat);
    chk(lat == 10, "R6 offset 0 selects chip5", lat, 10);
    chk(st_of(7) == 3, "R7 chip7 still down after chip5", st_of(7), 3);

    // R8: outstanding access blocks step down; count restarts on completion
    req_addr  = AW'(2 << CAW);
    req_valid = 1'b1;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(st_of(2) == 0, "R8 busy chip stays active", st_of(2), 0);
    done_valid = 1'b1;
    done_chip  = CW'(2);
    @(negedge clk);
    done_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(st_of(2) == 0, "R8 active before threshold", st_of(2), 0);
    @(negedge clk);
    chk(st_of(2) == 1, "R2 standby at threshold", st_of(2), 1);

    finish_up();
  end
endmodule